// File: doc/BRIEF.md
# Preset-Load Fixed Clock Divider

This block divides a fast system clock by a fixed integer, 2229 by default, to produce an audio-rate sample strobe. A 98.304 MHz input gives about 44.1 kHz, roughly 50 ppm off the nominal rate. Every output edge is tied to an input clock edge, so the divider adds no jitter of its own. The divider never compares the count against a terminal value. A 12-bit up-counter runs until a carry condition appears. On the next edge it is reloaded with a preset chosen so that one full lap, including the carry cycle, takes exactly the division ratio. Because no wide AND decode is needed, the loop stays shallow.

Two outputs are provided. The first, `tick_o`, is high for one input cycle per period and is meant to be used as a clock enable inside the chip. The second, `level_o`, is the counter's top counting bit. It stays high for a long stretch of each period and suits an external converter clock.

The parameter `USE_FLAG` selects how the carry is formed:
- With `USE_FLAG = 1`, a 13th flip-flop holds the carry out of the 12-bit counter.
- With `USE_FLAG = 0`, there is no extra flip-flop. The carry is taken as bits 11 and 10 both being one, and the preset is moved so that the period stays the same.

Top module: `clkdiv_preload`

## Requirements
- R1: `rst` is synchronous. An edge that samples `rst` high loads the preset with the carry clear. While `rst` is held, and in the cycle right after it, `tick_o` and `level_o` are both 0, in either option. No tick occurs while `rst` is held, however long.
- R2: `tick_o` is never high in two consecutive cycles.
- R3: After `rst` is released, the first tick appears after the 2228th rising edge (DIVIDE-1 edges). Every later tick follows the previous one by exactly DIVIDE = 2229 cycles.
- R4: With `USE_FLAG = 1`, the 13-bit register steps through the values 1868 to 4096. At 4096, bit 12 is set and that cycle is the tick. The register then reloads to 1868.
- R5: With `USE_FLAG = 1`, `level_o` is bit 11 of the count. Counting from the reload (offset 0 = preset), it is low for offsets 0 to 179, high for offsets 180 to 2227 (2048 cycles), and low in the tick cycle at offset 2228.
- R6: With `USE_FLAG = 0`, the 12-bit count starts at preset 844. The tick is the cycle in which bits 11 and 10 are both one (count 3072). The next edge reloads 844. The ticks fall in exactly the same cycles as with `USE_FLAG = 1` when both variants leave reset together.
- R7: With `USE_FLAG = 0`, `level_o` is bit 11 of the count. It is low for offsets 0 to 1203 and high for offsets 1204 to 2228, including the tick cycle.
- R8: Asserting `rst` for one cycle in the middle of a period restarts the phase. The next tick then follows the R3 timing from the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| tick_o | output | 1 | One-cycle strobe, once per period |
| level_o | output | 1 | Top counting bit, long-high level once per period |

## Verification
The hardest situation to reach from the ports is the carry-and-reload boundary. A tick appears only once every 2229 cycles, and the reload step sits between the last count and the preset. The bench therefore runs three full periods without interruption. It checks the cycles on both sides of each carry and the bit-11 transition points from a table of offsets.

It then forces a reset in the middle of a period, and holds a second reset longer than a whole period. These show that the phase restarts and that no tick slips through. Both carry options run side by side from the same reset, so that any difference in their pulse spacing shows up in the very cycle it occurs.

// File: rtl/clkdiv_preload.sv
module clkdiv_preload #(
  parameter int CNT_W    = 12,
  parameter int DIVIDE   = 2229,
  parameter bit USE_FLAG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic level_o
);

  localparam int SPAN = DIVIDE - 1;

  generate
    if (USE_FLAG) begin : g_flag
      localparam logic [CNT_W:0] PRESET = (CNT_W+1)'((1 << CNT_W) - SPAN);
      logic [CNT_W:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || cnt[CNT_W]) cnt <= PRESET;
        else                   cnt <= cnt + {{CNT_W{1'b0}}, 1'b1};
      end

      assign tick_o  = cnt[CNT_W];
      assign level_o = cnt[CNT_W-1];
    end else begin : g_pair
      localparam logic [CNT_W-1:0] PRESET = CNT_W'((3 << (CNT_W-2)) - SPAN);
      logic [CNT_W-1:0] cnt;
      logic             carry;

      assign carry = cnt[CNT_W-1] & cnt[CNT_W-2];

      always_ff @(posedge clk) begin
        if (rst || carry) cnt <= PRESET;
        else              cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
      end

      assign tick_o  = carry;
      assign level_o = cnt[CNT_W-1];
    end
  endgenerate

endmodule

// File: rtl/clkdiv_preload_chk.sv
module clkdiv_preload_chk #(
  parameter int CNT_W    = 12,
  parameter int DIVIDE   = 2229,
  parameter bit USE_FLAG = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic tick_o,
  input logic level_o
);

  localparam int HIGH_LEN = USE_FLAG ? (1 << (CNT_W-1)) : (1 << (CNT_W-2));

  int gap;
  int hi;

  always_ff @(posedge clk) begin
    if (rst || tick_o) begin
      gap <= 1;
      hi  <= 0;
    end else begin
      gap <= gap + 1;
      hi  <= hi + int'(level_o);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!tick_o && !level_o));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  a_r3_spacing: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> gap == DIVIDE);

  a_r3_gap_bound: assert property (@(posedge clk) disable iff (rst)
    gap <= DIVIDE);

  // R5 / R7: level in the tick cycle depends on the carry option
  a_r5_tick_level: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (level_o == !USE_FLAG));

  // R5 / R7: high time before each tick
  a_r7_high_len: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> hi == HIGH_LEN);

endmodule

bind clkdiv_preload clkdiv_preload_chk #(
  .CNT_W(CNT_W), .DIVIDE(DIVIDE), .USE_FLAG(USE_FLAG)
) u_chk (
  .clk(clk), .rst(rst), .tick_o(tick_o), .level_o(level_o)
);

// File: tb/sim_clkdiv_preload.sv
module sim_clkdiv_preload;

  localparam int DIV   = 2229;
  localparam int LOW_A = 2048 - 1868;
  localparam int LOW_B = 2048 - 844;
  localparam int NV    = 13;
  localparam int VK[NV] = '{0, 1, 179, 180, 181, 1000, 2227, 2228, 2229, 2408, 2409, 4457, 4458};
  localparam bit VT[NV] = '{0, 0, 0,   0,   0,   0,    0,    1,    0,    0,    0,    1,    0};
  localparam bit VL[NV] = '{0, 0, 0,   1,   1,   1,    1,    0,    0,    0,    1,    0,    0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_a, level_a, tick_b, level_b;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  clkdiv_preload #(.USE_FLAG(1'b1)) u0 (.clk(clk), .rst(rst), .tick_o(tick_a), .level_o(level_a));
  clkdiv_preload #(.USE_FLAG(1'b0)) u1 (.clk(clk), .rst(rst), .tick_o(tick_b), .level_o(level_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int vi;
    int first_a, first_b;
    bit seen;

    repeat (3) @(negedge clk);
    chk(tick_a == 0 && level_a == 0, "R1 flag reset", {tick_a, level_a}, 0);
    chk(tick_b == 0 && level_b == 0, "R1 pair reset", {tick_b, level_b}, 0);

    rst = 1'b0;
    vi = 0;
    for (int k = 0; k <= 3 * DIV; k++) begin
      if (k > 0) @(negedge clk);
      if (vi < NV && k == VK[vi]) begin
        chk(tick_a == VT[vi], "R4 flag tick vector", tick_a, VT[vi]);
        chk(level_a == VL[vi], "R5 flag level vector", level_a, VL[vi]);
        vi++;
      end
      chk(tick_a == ((k % DIV) == DIV - 1), "R3 flag spacing", tick_a, (k % DIV) == DIV - 1);
      chk(level_a == ((k % DIV) >= LOW_A && (k % DIV) != DIV - 1), "R5 flag level", level_a,
          (k % DIV) >= LOW_A && (k % DIV) != DIV - 1);
      chk(tick_b == tick_a, "R6 pair tick matches flag", tick_b, tick_a);
      chk(level_b == ((k % DIV) >= LOW_B), "R7 pair level", level_b, (k % DIV) >= LOW_B);
    end
    chk(vi == NV, "R4 table walked", vi, NV);

    repeat (1000) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(tick_a == 0 && level_a == 0, "R1 mid reset flag", {tick_a, level_a}, 0);
    chk(tick_b == 0 && level_b == 0, "R1 mid reset pair", {tick_b, level_b}, 0);
    rst = 1'b0;
    first_a = -1;
    first_b = -1;
    for (int n = 0; n <= DIV + 5; n++) begin
      if (n > 0) @(negedge clk);
      if (tick_a && first_a < 0) first_a = n;
      if (tick_b && first_b < 0) first_b = n;
      if (n > 0 && tick_a) chk(1'b1, "R2 pulse", 1, 1);
    end
    chk(first_a == DIV - 1, "R8 flag restart phase", first_a, DIV - 1);
    chk(first_b == DIV - 1, "R8 pair restart phase", first_b, DIV - 1);

    @(negedge clk);
    while (!tick_a) @(negedge clk);
    @(negedge clk);
    chk(tick_a == 0, "R2 single cycle flag", tick_a, 0);
    chk(tick_b == 0, "R2 single cycle pair", tick_b, 0);

    rst = 1'b1;
    seen = 1'b0;
    for (int n = 0; n < DIV + 10; n++) begin
      @(negedge clk);
      if (tick_a || tick_b || level_a || level_b) seen = 1'b1;
    end
    chk(!seen, "R1 long reset quiet", seen, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tick_a == 0 && level_a == 0, "R1 after release", {tick_a, level_a}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule